// File: doc/BRIEF.md
# Addressing-Mode Effective Address Unit

This unit sits between instruction decode and execute. It takes an instruction's 4-bit mode field and its 16-bit address-or-operand field. It then resolves the operand through one of ten addressing modes. Some modes need no memory: the operand is the field itself, a register's contents, or nothing at all. The other modes form an effective address, read a synchronous one-cycle-latency memory port once or twice, and return the word that was read. The effective address is built from the field, the advanced program counter, an index register or a register-file entry, depending on the mode.

The two auto-stepping modes use the selected register as the address. In the same cycle that the address goes out to memory, they write the register back, incremented or decremented by one. A one-cycle `start` launches an operation. When the operation ends, the unit gives a one-cycle `operand_valid` pulse, or an `illegal_mode` pulse for an unknown mode code. While it is busy it ignores further requests.

Top module: `ea_unit`

## Requirements
- R1: After reset, and whenever `busy` is low, `operand_valid`, `illegal_mode`, `mem_req` and `rf_we` are low.
- R2: Mode 1 (immediate) returns `field` as the operand with no memory request; `operand_valid` rises two clocks after the edge that samples `start`.
- R3: Mode 2 (direct) issues exactly one read at `field` and returns the read word; `operand_valid` is a single-cycle pulse three clocks after the start edge, and `eff_addr` equals `field`.
- R4: Mode 3 (indirect) reads at `field` and then reads at the word just returned; it returns the second word, with `eff_addr` equal to the first word, four clocks after the start edge. No operation issues more than two consecutive reads.
- R5: Mode 4 (relative) uses `field + pc` modulo 2^16 as the effective address, where `pc` is the already-advanced value sampled with `start`.
- R6: Mode 5 (indexed) uses `field + xr` modulo 2^16 as the effective address.
- R7: Mode 6 (register) returns the contents of register `field[2:0]`, with no memory request, two clocks after the start edge.
- R8: Mode 7 (register-indirect) reads memory at the contents of register `field[2:0]` and leaves that register unchanged.
- R9: Mode 8 (auto-increment) and mode 9 (auto-decrement) read at the register's old contents, then write back old+1 or old-1 modulo 2^16, exactly once per operation, in the same cycle as the read request.
- R10: Mode codes 10 to 15 raise a one-cycle `illegal_mode` two clocks after the start edge, with no `operand_valid`, no memory request and no register write.
- R11: Mode 0 (implied) completes with operand 0 and no memory request two clocks after the start edge.
- R12: `start` is ignored while `busy` is high, and `busy` falls the cycle after the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin resolving the presented mode and field |
| mode | input | 4 | Addressing-mode code, 0 to 9 legal |
| field | input | 16 | Address-or-operand field; low 3 bits select the register |
| pc | input | 16 | Program counter already advanced past the instruction |
| xr | input | 16 | Index register contents |
| rf_raddr | output | 3 | Register-file read select (follows `field`) |
| rf_rdata | input | 16 | Register-file read data, combinational |
| rf_we | output | 1 | Register write-back enable |
| rf_waddr | output | 3 | Register write-back select |
| rf_wdata | output | 16 | Register write-back value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid one clock after the request |
| operand | output | 16 | Resolved operand |
| operand_valid | output | 1 | One-cycle completion strobe |
| eff_addr | output | 16 | Final effective address of memory modes |
| illegal_mode | output | 1 | One-cycle strobe for an unknown mode |
| busy | output | 1 | Operation in progress |

## Verification
A corrupted state sequence shows at the ports as a completion pulse that comes one or more clocks early or late, or as a wrong number of `mem_req` cycles. Every directed operation measures these against exact figures of two, three or four clocks. A bad latched field, register value or pointer shows as a wrong `eff_addr` or `operand` at the completion pulse. A mistaken write-back shows in the modelled register file one clock after the address cycle. A start that leaks through while busy shows as an extra strobe or as an operand from the wrong mode, within the same operation.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_IMPL = 4'd0,
    AM_IMM  = 4'd1,
    AM_DIR  = 4'd2,
    AM_IND  = 4'd3,
    AM_REL  = 4'd4,
    AM_IDX  = 4'd5,
    AM_REG  = 4'd6,
    AM_RIND = 4'd7,
    AM_AINC = 4'd8,
    AM_ADEC = 4'd9
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_IND  = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } ea_state_e;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    mode,
  input  logic [DW-1:0] fld,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] xr,
  input  logic [DW-1:0] rval,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] direct_val,
  output logic          needs_mem,
  output logic          two_step,
  output logic          wb_en,
  output logic [DW-1:0] wb_val,
  output logic          bad
);
  always_comb begin
    ea         = fld;
    direct_val = '0;
    needs_mem  = 1'b0;
    two_step   = 1'b0;
    wb_en      = 1'b0;
    wb_val     = rval;
    bad        = 1'b0;
    case (amode_e'(mode))
      AM_IMPL: direct_val = '0;
      AM_IMM:  direct_val = fld;
      AM_DIR:  needs_mem = 1'b1;
      AM_IND: begin
        needs_mem = 1'b1;
        two_step  = 1'b1;
      end
      AM_REL: begin
        needs_mem = 1'b1;
        ea        = fld + pc;
      end
      AM_IDX: begin
        needs_mem = 1'b1;
        ea        = fld + xr;
      end
      AM_REG:  direct_val = rval;
      AM_RIND: begin
        needs_mem = 1'b1;
        ea        = rval;
      end
      AM_AINC: begin
        needs_mem = 1'b1;
        ea        = rval;
        wb_en     = 1'b1;
        wb_val    = rval + DW'(1);
      end
      AM_ADEC: begin
        needs_mem = 1'b1;
        ea        = rval;
        wb_en     = 1'b1;
        wb_val    = rval - DW'(1);
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm
  import ea_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      needs_mem,
  input  logic      two_step,
  output ea_state_e state
);
  ea_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ADDR;
      ST_ADDR: begin
        if (!needs_mem)    state_d = ST_DONE;
        else if (two_step) state_d = ST_IND;
        else               state_d = ST_DATA;
      end
      ST_IND:  state_d = ST_DATA;
      ST_DATA: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DW = 16,
  parameter int RN = 8,
  localparam int RAW = $clog2(RN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     mode,
  input  logic [DW-1:0]  field,
  input  logic [DW-1:0]  pc,
  input  logic [DW-1:0]  xr,
  output logic [RAW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RAW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  operand,
  output logic           operand_valid,
  output logic [DW-1:0]  eff_addr,
  output logic           illegal_mode,
  output logic           busy
);
  logic           rst_ns;
  ea_state_e      state;
  logic [3:0]     mode_q;
  logic [DW-1:0]  fld_q, pc_q, xr_q, rval_q, ea_q, opnd_q;
  logic [RAW-1:0] sel_q;
  logic           bad_q;
  logic [DW-1:0]  ea_c, dval_c, wbv_c;
  logic           nmem_c, two_c, wben_c, bad_c;
  logic           ld_en, in_addr, in_ind, in_data;

  ea_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  assign ld_en   = start && (state == ST_IDLE);
  assign in_addr = (state == ST_ADDR);
  assign in_ind  = (state == ST_IND);
  assign in_data = (state == ST_DATA);

  ea_fsm u_fsm (
    .clk(clk), .rst_n(rst_ns), .start(start),
    .needs_mem(nmem_c && !bad_c), .two_step(two_c), .state(state)
  );

  ea_addr_gen #(.DW(DW)) u_gen (
    .mode(mode_q), .fld(fld_q), .pc(pc_q), .xr(xr_q), .rval(rval_q),
    .ea(ea_c), .direct_val(dval_c), .needs_mem(nmem_c), .two_step(two_c),
    .wb_en(wben_c), .wb_val(wbv_c), .bad(bad_c)
  );

  // request capture, clock-enabled by an accepted start
  always_ff @(posedge clk) begin
    if (ld_en) begin
      mode_q <= mode;
      fld_q  <= field;
      pc_q   <= pc;
      xr_q   <= xr;
      rval_q <= rf_rdata;
      sel_q  <= field[RAW-1:0];
    end
  end

  // address and operand holding registers
  always_ff @(posedge clk) begin
    if (in_addr)     ea_q <= ea_c;
    else if (in_ind) ea_q <= mem_rdata;
    if (in_addr && !nmem_c) opnd_q <= dval_c;
    else if (in_data)       opnd_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      bad_q <= 1'b0;
    else if (in_addr) bad_q <= bad_c;
  end

  assign rf_raddr      = field[RAW-1:0];
  assign rf_we         = in_addr && wben_c;
  assign rf_waddr      = sel_q;
  assign rf_wdata      = wbv_c;
  assign mem_req       = (in_addr && nmem_c) || in_ind;
  assign mem_addr      = in_ind ? mem_rdata : ea_c;
  assign operand       = opnd_q;
  assign eff_addr      = ea_q;
  assign operand_valid = (state == ST_DONE) && !bad_q;
  assign illegal_mode  = (state == ST_DONE) && bad_q;
  assign busy          = (state != ST_IDLE);
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          rf_we,
  input logic          operand_valid,
  input logic          illegal_mode
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we && !operand_valid && !illegal_mode));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    operand_valid |=> !operand_valid);

  // R10
  ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> !operand_valid);

  // R4
  two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |=> !mem_req);

  // R9
  wb_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_req);

  // R12
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (operand_valid || illegal_mode) |=> !busy);
endmodule

bind ea_unit ea_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .rf_we(rf_we),
  .operand_valid(operand_valid), .illegal_mode(illegal_mode)
);

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;
  logic        clk, rst_n, start;
  logic [3:0]  mode;
  logic [15:0] field, pc, xr, rf_rdata, rf_wdata, mem_addr, mem_rdata;
  logic [15:0] operand, eff_addr;
  logic [2:0]  rf_raddr, rf_waddr;
  logic        rf_we, mem_req, operand_valid, illegal_mode, busy;

  int checks = 0, fails = 0;
  int req_cnt = 0, we_cnt = 0, vld_cnt = 0;
  logic [15:0] first_addr;
  logic [15:0] rf [8];

  ea_unit u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= memf(mem_addr);
      if (req_cnt == 0) first_addr <= mem_addr;
      req_cnt <= req_cnt + 1;
    end
    if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (operand_valid) vld_cnt <= vld_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] m, input logic [15:0] f,
                        input logic [15:0] p, input logic [15:0] x,
                        input logic [15:0] exp_op, input int exp_lat, input int exp_reqs,
                        input bit chk_ea, input logic [15:0] exp_ea, input bit exp_ill);
    int cnt;
    @(negedge clk);
    req_cnt = 0; we_cnt = 0; vld_cnt = 0;
    start = 1'b1; mode = m; field = f; pc = p; xr = x;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!(operand_valid || illegal_mode) && cnt < 12) begin
      @(negedge clk);
      cnt++;
    end
    check({req, " latency"}, cnt, exp_lat);
    check({req, " illegal"}, illegal_mode, exp_ill);
    check({req, " valid"}, operand_valid, !exp_ill);
    if (!exp_ill) check({req, " operand"}, operand, exp_op);
    if (chk_ea) begin
      check({req, " eff_addr"}, eff_addr, exp_ea);
      check({req, " first read addr"}, first_addr, chk_ea && m == 4'd3 ? f : exp_ea);
    end
    check({req, " read count"}, req_cnt, exp_reqs);
    @(negedge clk);
    check({req, " busy released"}, busy, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 reset valid", operand_valid, 1'b0);
    check("R1 reset req", mem_req, 1'b0);
    check("R1 reset we", rf_we, 1'b0);
    check("R1 reset busy", busy, 1'b0);
    check("R1 reset illegal", illegal_mode, 1'b0);
  endtask

  task automatic t_implied();
    run_op("R11 implied", 4'd0, 16'h1234, 16'h0, 16'h0, 16'h0000, 2, 0, 0, 16'h0, 0);
  endtask

  task automatic t_immediate();
    run_op("R2 immediate", 4'd1, 16'd500, 16'd252, 16'h0, 16'd500, 2, 0, 0, 16'h0, 0);
  endtask

  task automatic t_direct();
    run_op("R3 direct", 4'd2, 16'h0123, 16'h0, 16'h0, memf(16'h0123), 3, 1, 1, 16'h0123, 0);
    check("R3 single valid pulse", vld_cnt, 1);
  endtask

  task automatic t_indirect();
    logic [15:0] ptr;
    ptr = memf(16'h0300);
    run_op("R4 indirect", 4'd3, 16'h0300, 16'h0, 16'h0, memf(ptr), 4, 2, 1, ptr, 0);
  endtask

  task automatic t_relative();
    run_op("R5 relative", 4'd4, 16'd500, 16'd252, 16'h0, memf(16'd752), 3, 1, 1, 16'd752, 0);
    run_op("R5 relative wrap", 4'd4, 16'hFFF0, 16'h0020, 16'h0, memf(16'h0010), 3, 1, 1, 16'h0010, 0);
  endtask

  task automatic t_indexed();
    run_op("R6 indexed", 4'd5, 16'd500, 16'h0, 16'd400, memf(16'd900), 3, 1, 1, 16'd900, 0);
    run_op("R6 indexed wrap", 4'd5, 16'hFFFF, 16'h0, 16'h0002, memf(16'h0001), 3, 1, 1, 16'h0001, 0);
  endtask

  task automatic t_register();
    rf[3] = 16'hBEEF;
    run_op("R7 register", 4'd6, 16'h0003, 16'h0, 16'h0, 16'hBEEF, 2, 0, 0, 16'h0, 0);
  endtask

  task automatic t_reg_ind();
    rf[5] = 16'h0700;
    run_op("R8 reg-indirect", 4'd7, 16'h0005, 16'h0, 16'h0, memf(16'h0700), 3, 1, 1, 16'h0700, 0);
    check("R8 no write-back", we_cnt, 0);
    check("R8 register kept", rf[5], 16'h0700);
  endtask

  task automatic t_auto();
    rf[2] = 16'hFFFF;
    run_op("R9 auto-increment", 4'd8, 16'h0002, 16'h0, 16'h0, memf(16'hFFFF), 3, 1, 1, 16'hFFFF, 0);
    check("R9 inc write count", we_cnt, 1);
    check("R9 inc register", rf[2], 16'h0000);
    rf[6] = 16'h0000;
    run_op("R9 auto-decrement", 4'd9, 16'h0006, 16'h0, 16'h0, memf(16'h0000), 3, 1, 1, 16'h0000, 0);
    check("R9 dec write count", we_cnt, 1);
    check("R9 dec register", rf[6], 16'hFFFF);
  endtask

  task automatic t_illegal();
    run_op("R10 illegal 10", 4'd10, 16'h0040, 16'h0, 16'h0, 16'h0, 2, 0, 0, 16'h0, 1);
    check("R10 no write 10", we_cnt, 0);
    run_op("R10 illegal 15", 4'd15, 16'h0041, 16'h0, 16'h0, 16'h0, 2, 0, 0, 16'h0, 1);
    check("R10 no valid 15", vld_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    int cnt;
    @(negedge clk);
    req_cnt = 0; vld_cnt = 0;
    start = 1'b1; mode = 4'd2; field = 16'h0456;
    @(negedge clk);
    mode = 4'd1; field = 16'h7777;
    @(negedge clk);
    start = 1'b0;
    cnt = 2;
    while (!operand_valid && cnt < 12) begin
      @(negedge clk);
      cnt++;
    end
    check("R12 latency under extra start", cnt, 3);
    check("R12 operand from first request", operand, memf(16'h0456));
    repeat (4) @(negedge clk);
    check("R12 one completion only", vld_cnt, 1);
    check("R12 one read only", req_cnt, 1);
    check("R12 idle after", busy, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 16'h0;
    rst_n = 1'b0; start = 1'b0; mode = 4'd0; field = 16'h0; pc = 16'h0; xr = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_implied();
    t_immediate();
    t_direct();
    t_indirect();
    t_relative();
    t_indexed();
    t_register();
    t_reg_ind();
    t_auto();
    t_illegal();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule